// File: doc/BRIEF.md
# Bus Wait-State Generator

This block paces a processor bus cycle. A cycle runs through the fixed phases T1, T2 and T3, then zero or more wait phases (Tw), and ends with T4. The block tracks the phase, holds the command window open from T3 to the last Tw, and drives a READY line. READY is examined at the end of T3 and at the end of every Tw. When READY is high the cycle moves to T4. When it is low, one more Tw follows.

The length of the wait depends on which device the cycle addresses, and this is latched when the cycle starts. Each on-board class (RAM, ROM, I/O) has its own strap, which selects one or two wait states. An off-board cycle waits for an external acknowledge instead of counting. That acknowledge comes from another clock domain, so it passes through a synchroniser first. A timeout counter ends an off-board cycle that is never acknowledged and raises an error flag for its T4. A useful sizing rule for the straps is: needed waits = ceil((device response − 4 clocks) / 1 clock).

All pins are plain control and status lines. No data flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `bus_wait_gen`

## Requirements
- R1: The `phase` output uses this encoding: idle=0, T1=1, T2=2, T3=3, Tw=4, T4=5. `cyc_start` sampled high in idle or in T4 makes the next phase T1. T1 is always followed by T2, and T2 by T3. `cyc_start` in T1, T2, T3 or Tw has no effect.
- R2: `ready` is high only in T3 or Tw. If it is high there, the next phase is T4. If it is low there, the next phase is Tw. It is low in T1, T2 and T4.
- R3: The device class and the wait straps are captured at the clock edge that accepts `cyc_start`. Later changes to the selects or straps do not change the current cycle's Tw count.
- R4: The on-board Tw count is 1 when the class strap is 0 and 2 when it is 1. The straps are `ram_two_ws`, `rom_two_ws` and `io_two_ws`, one per class and each independent of the others. Tying a strap low gives the default of one wait state.
- R5: Class priority is `ram_sel` > `rom_sel` > `io_sel` > `offboard`. A cycle with no select asserted has zero Tw (T3 goes straight to T4).
- R6: `ack_in` passes through two synchronising flops. In an off-board cycle, number the cycle clocks from 0 at T1. If `ack_in` is raised in clock j and held, the cycle has exactly j Tw states, as long as j does not exceed TMO_LIMIT.
- R7: An off-board cycle has at most TMO_LIMIT Tw states. The cycle times out only if no synchronised acknowledge is present by its last allowed Tw. In that case it ends with T4 and `tmo_err` is high for exactly that T4 clock. `tmo_err` is low in every other clock.
- R8: `cmd_act` is high in T3 and in every Tw, and low in idle, T1, T2 and T4.
- R9: After reset, `phase` is idle and `ready`, `cmd_act` and `tmo_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Request to begin a bus cycle |
| ram_sel | input | 1 | Cycle addresses on-board RAM |
| rom_sel | input | 1 | Cycle addresses on-board ROM |
| io_sel | input | 1 | Cycle addresses on-board I/O |
| offboard | input | 1 | Cycle goes to the system bus |
| ram_two_ws | input | 1 | RAM strap: 0 = one wait, 1 = two waits |
| rom_two_ws | input | 1 | ROM strap: 0 = one wait, 1 = two waits |
| io_two_ws | input | 1 | I/O strap: 0 = one wait, 1 = two waits |
| ack_in | input | 1 | Asynchronous off-board acknowledge |
| ready | output | 1 | Wait-end indication, examined in T3/Tw |
| cmd_act | output | 1 | Command/transceiver window (T3 through Tw) |
| tmo_err | output | 1 | Off-board timeout flag, high during T4 |
| phase | output | 3 | Current bus phase (encoding in R1) |

## Verification
The bench builds the block with TMO_LIMIT set to 20 and SYNC_STAGES left at its default of 2. This lets off-board cycles reach the timeout boundary within a few dozen clocks. Acknowledges at j = 20 (exactly the limit, no error) and j = 21 or never (timeout) both fall within reach. With the two-flop default, the bench can predict the Tw count from the clock in which it raises the acknowledge.

// File: rtl/bwg_pkg.sv
package bwg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  typedef enum logic [2:0] {
    DC_NONE = 3'd0,
    DC_RAM  = 3'd1,
    DC_ROM  = 3'd2,
    DC_IO   = 3'd3,
    DC_OFF  = 3'd4
  } dev_cls_e;

  function automatic logic may_launch(phase_e p);
    return (p == PH_IDLE) || (p == PH_T4);
  endfunction

  function automatic logic in_wait_window(phase_e p);
    return (p == PH_T3) || (p == PH_TW);
  endfunction

endpackage

// File: rtl/bwg_sync.sv
module bwg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/bwg_class_sel.sv
module bwg_class_sel
  import bwg_pkg::*;
(
  input  logic       ram_sel,
  input  logic       rom_sel,
  input  logic       io_sel,
  input  logic       offboard,
  input  logic       ram_two_ws,
  input  logic       rom_two_ws,
  input  logic       io_two_ws,
  output dev_cls_e   cls,
  output logic [1:0] need
);

  always_comb begin
    cls  = DC_NONE;
    need = 2'd0;
    if (ram_sel) begin
      cls  = DC_RAM;
      need = ram_two_ws ? 2'd2 : 2'd1;
    end else if (rom_sel) begin
      cls  = DC_ROM;
      need = rom_two_ws ? 2'd2 : 2'd1;
    end else if (io_sel) begin
      cls  = DC_IO;
      need = io_two_ws ? 2'd2 : 2'd1;
    end else if (offboard) begin
      cls  = DC_OFF;
      need = 2'd0;
    end
  end

endmodule

// File: rtl/bwg_phase_fsm.sv
module bwg_phase_fsm
  import bwg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cyc_start,
  input  logic   ready,
  output phase_e phase,
  output logic   launch
);

  phase_e phase_q, phase_d;

  assign launch = cyc_start && may_launch(phase_q);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:      phase_d = launch ? PH_T1 : PH_IDLE;
      PH_T1:        phase_d = PH_T2;
      PH_T2:        phase_d = PH_T3;
      PH_T3, PH_TW: phase_d = ready ? PH_T4 : PH_TW;
      PH_T4:        phase_d = launch ? PH_T1 : PH_IDLE;
      default:      phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

endmodule

// File: rtl/bwg_wait_ctl.sv
module bwg_wait_ctl
  import bwg_pkg::*;
#(
  parameter int TMO_LIMIT = 600,
  parameter int TMO_W     = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  phase_e     phase,
  input  logic       launch,
  input  dev_cls_e   cls_in,
  input  logic [1:0] need_in,
  input  logic       ack_s,
  output logic       ready,
  output logic       tmo_err
);

  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_LIMIT - 1);

  dev_cls_e         cls_q;
  logic [1:0]       need_q;
  logic [1:0]       wcnt_q;
  logic [TMO_W-1:0] tcnt_q;
  logic             tmo_q;

  logic off_c;
  logic onb_done;
  logic tmo_hit;

  assign off_c = (cls_q == DC_OFF);

  // On-board: T3 ends the wait only when no Tw is needed; Tw number k (0-based) ends it once k+1 reaches the need.
  always_comb begin
    if (phase == PH_T3) onb_done = (need_q == 2'd0);
    else                onb_done = (({1'b0, wcnt_q} + 3'd1) >= {1'b0, need_q});
  end

  assign tmo_hit = off_c && (phase == PH_TW) && !ack_s && (tcnt_q == TMO_LAST);

  assign ready = in_wait_window(phase) && (off_c ? (ack_s || tmo_hit) : onb_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q  <= DC_NONE;
      need_q <= 2'd0;
      wcnt_q <= 2'd0;
      tcnt_q <= '0;
      tmo_q  <= 1'b0;
    end else begin
      tmo_q <= tmo_hit;
      if (launch) begin
        cls_q  <= cls_in;
        need_q <= need_in;
        wcnt_q <= 2'd0;
        tcnt_q <= '0;
      end else if (phase == PH_TW) begin
        if (wcnt_q != 2'd3) wcnt_q <= wcnt_q + 2'd1;
        if (off_c && (tcnt_q != TMO_LAST)) tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign tmo_err = tmo_q;

endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import bwg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TMO_LIMIT   = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_start,
  input  logic       ram_sel,
  input  logic       rom_sel,
  input  logic       io_sel,
  input  logic       offboard,
  input  logic       ram_two_ws,
  input  logic       rom_two_ws,
  input  logic       io_two_ws,
  input  logic       ack_in,
  output logic       ready,
  output logic       cmd_act,
  output logic       tmo_err,
  output logic [2:0] phase
);

  localparam int TMO_W = $clog2(TMO_LIMIT + 1);

  phase_e     phase_w;
  logic       launch_w;
  logic       ack_s;
  dev_cls_e   cls_w;
  logic [1:0] need_w;
  logic       ready_w;

  bwg_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ack_in),
    .q     (ack_s)
  );

  bwg_class_sel u_class_sel (
    .ram_sel    (ram_sel),
    .rom_sel    (rom_sel),
    .io_sel     (io_sel),
    .offboard   (offboard),
    .ram_two_ws (ram_two_ws),
    .rom_two_ws (rom_two_ws),
    .io_two_ws  (io_two_ws),
    .cls        (cls_w),
    .need       (need_w)
  );

  bwg_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .ready     (ready_w),
    .phase     (phase_w),
    .launch    (launch_w)
  );

  bwg_wait_ctl #(.TMO_LIMIT(TMO_LIMIT), .TMO_W(TMO_W)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase_w),
    .launch  (launch_w),
    .cls_in  (cls_w),
    .need_in (need_w),
    .ack_s   (ack_s),
    .ready   (ready_w),
    .tmo_err (tmo_err)
  );

  assign ready   = ready_w;
  assign cmd_act = in_wait_window(phase_w);
  assign phase   = phase_w;

endmodule

// File: rtl/bwg_chk.sv
module bwg_chk #(
  parameter int TMO_LIMIT = 600
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_start,
  input logic       ready,
  input logic       cmd_act,
  input logic       tmo_err,
  input logic [2:0] phase
);

  int unsigned tw_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tw_run <= 0;
    else if (phase == 3'd4) tw_run <= tw_run + 1;
    else                    tw_run <= 0;
  end

  p_launch_t1_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == 3'd0 || phase == 3'd5) && cyc_start) |=> (phase == 3'd1));

  p_t1_to_t2_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1) |=> (phase == 3'd2));

  p_t2_to_t3_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2) |=> (phase == 3'd3));

  p_ready_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (phase == 3'd3 || phase == 3'd4));

  p_ready_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == 3'd3 || phase == 3'd4) && ready) |=> (phase == 3'd5));

  p_notready_waits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == 3'd3 || phase == 3'd4) && !ready) |=> (phase == 3'd4));

  p_cmd_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_act) |-> (phase == 3'd3));

  p_cmd_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_act) |-> (phase == 3'd5));

  p_tmo_in_t4_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> (phase == 3'd5));

  p_tw_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tw_run <= TMO_LIMIT);

endmodule

bind bus_wait_gen bwg_chk #(.TMO_LIMIT(TMO_LIMIT)) u_bwg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_start (cyc_start),
  .ready     (ready),
  .cmd_act   (cmd_act),
  .tmo_err   (tmo_err),
  .phase     (phase)
);

// File: tb/test_bus_wait_gen.sv
module test_bus_wait_gen;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 20;
  localparam int NEVER      = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0;
  logic ram_sel = 1'b0, rom_sel = 1'b0, io_sel = 1'b0, offboard = 1'b0;
  logic ram_two_ws = 1'b0, rom_two_ws = 1'b0, io_two_ws = 1'b0;
  logic ack_in = 1'b0;
  logic ready, cmd_act, tmo_err;
  logic [2:0] phase;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_wait_gen #(.SYNC_STAGES(2), .TMO_LIMIT(TMO)) i_bus_wait_gen (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .ram_sel(ram_sel), .rom_sel(rom_sel), .io_sel(io_sel), .offboard(offboard),
    .ram_two_ws(ram_two_ws), .rom_two_ws(rom_two_ws), .io_two_ws(io_two_ws),
    .ack_in(ack_in), .ready(ready), .cmd_act(cmd_act), .tmo_err(tmo_err),
    .phase(phase)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // sel bits: [0] ram, [1] rom, [2] io, [3] offboard. Class: 0 none, 1 ram, 2 rom, 3 io, 4 off
  function automatic int eff_cls(input bit [3:0] sel);
    if (sel[0]) return 1;
    if (sel[1]) return 2;
    if (sel[2]) return 3;
    if (sel[3]) return 4;
    return 0;
  endfunction

  function automatic int exp_waits(input bit [3:0] sel, input bit [2:0] two, input int ackj);
    case (eff_cls(sel))
      1: return two[0] ? 2 : 1;
      2: return two[1] ? 2 : 1;
      3: return two[2] ? 2 : 1;
      4: return (ackj < TMO) ? ackj : TMO;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_err(input bit [3:0] sel, input int ackj);
    return (eff_cls(sel) == 4) && (ackj > TMO);
  endfunction

  task automatic drive_sel(input bit [3:0] sel, input bit [2:0] two);
    {offboard, io_sel, rom_sel, ram_sel} = sel;
    {io_two_ws, rom_two_ws, ram_two_ws}  = two;
  endtask

  task automatic run_bus(input bit [3:0] sel, input bit [2:0] two, input int ackj,
                         input bit disturb, input bit chain, input string req);
    int n = 0;
    int tw = 0;
    bit prev_rdy = 1'b0, prevwait = 1'b0;
    bit bad_ready = 1'b0, bad_cmd = 1'b0, early_err = 1'b0, err_seen = 1'b0;
    logic [2:0] ph;
    int ew = exp_waits(sel, two, ackj);
    bit ee = exp_err(sel, ackj);
    @(negedge clk);
    drive_sel(sel, two);
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    check(phase == 3'd1, "R1 start->T1", int'(phase), 1);
    forever begin
      ph = phase;
      if (prevwait && ((ph == 3'd5) != prev_rdy)) bad_ready = 1'b1;
      if ((ph == 3'd1 || ph == 3'd2 || ph == 3'd5) && ready) bad_ready = 1'b1;
      if (cmd_act != (ph == 3'd3 || ph == 3'd4)) bad_cmd = 1'b1;
      if (ph == 3'd4) tw++;
      if (ph == 3'd5) begin
        err_seen = tmo_err;
        break;
      end
      if (tmo_err) early_err = 1'b1;
      prevwait = (ph == 3'd3 || ph == 3'd4);
      prev_rdy = ready;
      if (eff_cls(sel) == 4 && n == ackj) ack_in = 1'b1;
      if (disturb && n == 1) begin
        drive_sel(~sel, ~two);
        cyc_start = 1'b1;
      end
      if (disturb && n == 2) cyc_start = 1'b0;
      n++;
      if (n > TMO + 10) break;
      @(negedge clk);
    end
    ack_in = 1'b0;
    check(tw == ew, {req, " Tw count"}, tw, ew);
    check(err_seen == ee && !early_err, "R7 timeout flag", int'(err_seen), int'(ee));
    check(!bad_ready, "R2 ready timing", int'(bad_ready), 0);
    check(!bad_cmd, "R8 command window", int'(bad_cmd), 0);
    if (chain) begin
      drive_sel(4'b0001, 3'b000);
      cyc_start = 1'b1;
      @(negedge clk);
      cyc_start = 1'b0;
      check(phase == 3'd1, "R1 T4->T1 back-to-back", int'(phase), 1);
      n = 0;
      while (phase != 3'd0 && n < 20) begin
        @(negedge clk);
        n++;
      end
      check(n == 5, "R1 chained cycle length", n, 5);
    end else begin
      cyc_start = 1'b0;
      @(negedge clk);
      check(phase == 3'd0 && !tmo_err, "R1 idle after T4", int'(phase), 0);
    end
    drive_sel(4'b0000, 3'b000);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check(phase == 3'd0 && !ready && !cmd_act && !tmo_err, "R9 reset state",
          int'({phase, ready, cmd_act, tmo_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(phase == 3'd0 && !ready && !cmd_act && !tmo_err, "R9 after release",
          int'({phase, ready, cmd_act, tmo_err}), 0);

    // R4 per-class straps, other straps set opposite
    run_bus(4'b0001, 3'b110, 0, 0, 0, "R4 ram one");
    run_bus(4'b0001, 3'b001, 0, 0, 0, "R4 ram two");
    run_bus(4'b0010, 3'b101, 0, 0, 0, "R4 rom one");
    run_bus(4'b0010, 3'b010, 0, 0, 0, "R4 rom two");
    run_bus(4'b0100, 3'b011, 0, 0, 0, "R4 io one");
    run_bus(4'b0100, 3'b100, 0, 0, 0, "R4 io two");
    // R5 priority and no-select
    run_bus(4'b0000, 3'b111, 0, 0, 0, "R5 none zero");
    run_bus(4'b1111, 3'b001, 0, 0, 0, "R5 ram wins");
    run_bus(4'b1110, 3'b100, 0, 0, 0, "R5 rom wins");
    run_bus(4'b1100, 3'b100, 0, 0, 0, "R5 io wins");
    // R6 off-board acknowledge
    run_bus(4'b1000, 3'b111, 0, 0, 0, "R6 ack j0");
    run_bus(4'b1000, 3'b000, 1, 0, 0, "R6 ack j1");
    run_bus(4'b1000, 3'b000, 5, 0, 0, "R6 ack j5");
    // R7 timeout boundary
    run_bus(4'b1000, 3'b000, TMO, 0, 0, "R7 ack at limit");
    run_bus(4'b1000, 3'b000, TMO + 1, 0, 0, "R7 ack past limit");
    run_bus(4'b1000, 3'b000, NEVER, 0, 0, "R7 no ack");
    // R3 latched class, R1 start ignored mid-cycle
    run_bus(4'b0001, 3'b000, 0, 1, 0, "R3 disturbed ram");
    run_bus(4'b0100, 3'b100, 0, 1, 0, "R3 disturbed io");
    // R1 back-to-back
    run_bus(4'b0010, 3'b010, 0, 0, 1, "R1 chain first");

    for (int i = 0; i < 60; i++) begin
      bit [3:0] s = 4'($urandom_range(0, 15));
      bit [2:0] t = 3'($urandom_range(0, 7));
      int j = $urandom_range(0, TMO + 4);
      bit d = 1'($urandom_range(0, 1));
      run_bus(s, t, j, d, 0, "R6 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule